// File: doc/BRIEF.md
# I2C Master Command and Receive Queue

This block is the queue between a host and the serial engine of an I2C master. The host writes 9-bit command words into a transmit queue. Each word asks the engine either to send one byte or to fetch one byte. Bytes the engine fetches land in a receive queue, and the host drains them with a read strobe. The serial engine is not part of this block. It sees the transmit queue as a head word with a valid flag and a pop strobe, and it feeds the receive queue through a push strobe.

Both queues report their occupancy all the time. Each occupancy is compared against a programmable level to produce the two service requests: the transmit queue wants refilling, and the receive queue wants draining. Three misuse events are reported as single-cycle pulses: writing a full transmit queue, pushing into a full receive queue, and reading an empty receive queue. A transfer abort empties both queues in one clock.

Top module: `i2cm_cmd_queue`

## Requirements
- R1: After reset both levels are 0, `eng_cmd_valid` is 0, `tx_empty_irq` is 1 for any threshold, `rx_full_irq` is 0 for any threshold, and all three event pulses are 0.
- R2: A command word with bit 8 clear is a write. Words reach the engine in the order they were written, with `eng_cmd_rd` = 0 and `eng_cmd_byte` equal to word bits 7:0. `eng_cmd_valid` is 1 exactly when the transmit level is nonzero.
- R3: A command word with bit 8 set is a read request. The engine sees `eng_cmd_rd` = 1 and `eng_cmd_byte` = 0, whatever bits 7:0 of the word held.
- R4: `tx_level` and `rx_level` give the current occupancy of each queue, from 0 to DEPTH inclusive. They change in the clock after an accepted write, pop or push.
- R5: `tx_empty_irq` is 1 exactly when `tx_level` is less than or equal to `tx_thresh`. With `tx_thresh` = DEPTH-1 it is 1 whenever the transmit queue is not full.
- R6: `rx_full_irq` is 1 exactly when `rx_level` is greater than `rx_thresh`. With `rx_thresh` = 0 it is 1 as soon as one byte is held.
- R7: While `host_rd_en` is high, `host_rd_data` shows the oldest received byte zero-extended to RD_W bits. At the clock edge that byte is removed.
- R8: A host write to a full transmit queue is dropped, and `tx_over` pulses high for the one clock that follows.
- R9: An engine push into a full receive queue is dropped, and `rx_over` pulses high for the one clock that follows.
- R10: A host read of an empty receive queue returns 0 and leaves the level at 0, and `rx_under` pulses high for the one clock that follows.
- R11: A cycle with `abort` high empties both queues at its clock edge. Any write, push, pop or read in that same cycle is ignored and raises no event.
- R12: An engine pop while the transmit queue is empty is ignored. The level stays 0 and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host writes a command word |
| host_wr_data | input | 9 | Command word: bit 8 = read request, bits 7:0 = byte to send |
| host_rd_en | input | 1 | Host reads and pops one received byte |
| host_rd_data | output | RD_W (16) | Oldest received byte, zero-extended; 0 when empty |
| tx_thresh | input | LVL_W (4) | Transmit service level |
| rx_thresh | input | LVL_W (4) | Receive service level |
| abort | input | 1 | Transfer abort: empties both queues |
| eng_cmd_valid | output | 1 | Transmit queue holds a command |
| eng_cmd_rd | output | 1 | Head command is a read request |
| eng_cmd_byte | output | 8 | Byte to send for a write command, else 0 |
| eng_cmd_pop | input | 1 | Engine consumes the head command |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| tx_level | output | LVL_W (4) | Transmit queue occupancy |
| rx_level | output | LVL_W (4) | Receive queue occupancy |
| tx_empty_irq | output | 1 | Transmit queue at or below its service level |
| rx_full_irq | output | 1 | Receive queue above its service level |
| tx_over | output | 1 | Pulse: write to a full transmit queue |
| rx_over | output | 1 | Pulse: push into a full receive queue |
| rx_under | output | 1 | Pulse: read of an empty receive queue |

## Verification
The bound checker watches the level bounds, the flush after abort, the silence of events in an abort cycle, and the one-clock pulses after overflow and underflow on every cycle. It also checks the link between each service request and its level and threshold, and the zero byte shown for read requests. Only the bench scenarios can show that command words come out intact and in write order, and that received bytes come back in push order and zero-extended. The same holds for dropped writes and pushes, which must leave the stored contents unchanged, and for the queues working normally again after a flush.

// File: rtl/i2cm_q_pkg.sv
package i2cm_q_pkg;
   localparam int BYTE_W = 8;
   localparam int CMD_W  = BYTE_W + 1;

   // command word: read-request flag sits above the data byte
   typedef struct packed {
      logic              rd;
      logic [BYTE_W-1:0] dat;
   } cmd_t;

   // event pulse indices
   localparam int EV_TX_OVER  = 0;
   localparam int EV_RX_OVER  = 1;
   localparam int EV_RX_UNDER = 2;
   localparam int EV_N        = 3;
endpackage

// File: rtl/i2cm_q_fifo.sv
module i2cm_q_fifo #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int PW   = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [PW-1:0]    level,
   output logic             full,
   output logic             empty
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("i2cm_q_fifo: DEPTH must be a power of two and at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wptr;
   logic [PW-1:0]    rptr;
   logic             push_ok;
   logic             pop_ok;

   // the extra wrap bit makes the pointer difference the occupancy
   assign level   = wptr - rptr;
   assign full    = (level == PW'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push & ~full & ~flush;
   assign pop_ok  = pop & ~empty & ~flush;
   assign dout    = mem[rptr[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else if (flush) begin
         wptr <= '0;
         rptr <= '0;
      end else begin
         if (push_ok) wptr <= wptr + PW'(1);
         if (pop_ok)  rptr <= rptr + PW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr[AW-1:0]] <= din;
   end
endmodule

// File: rtl/i2cm_q_thresh.sv
module i2cm_q_thresh #(
   parameter int LW    = 4,
   parameter bit ABOVE = 1'b0
) (
   input  logic [LW-1:0] level,
   input  logic [LW-1:0] thresh,
   output logic          hit
);
   generate
      if (ABOVE) begin : g_above
         assign hit = (level > thresh);
      end else begin : g_at_or_below
         assign hit = (level <= thresh);
      end
   endgenerate
endmodule

// File: rtl/i2cm_q_evt.sv
module i2cm_q_evt #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] raw,
   output logic [N-1:0] pulse
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_evt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pulse[i] <= 1'b0;
            else        pulse[i] <= raw[i];
         end
      end
   endgenerate
endmodule

// File: rtl/i2cm_cmd_queue.sv
module i2cm_cmd_queue
   import i2cm_q_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int RD_W   = 16,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr_en,
   input  logic [CMD_W-1:0]  host_wr_data,
   input  logic              host_rd_en,
   output logic [RD_W-1:0]   host_rd_data,
   input  logic [LVL_W-1:0]  tx_thresh,
   input  logic [LVL_W-1:0]  rx_thresh,
   input  logic              abort,
   output logic              eng_cmd_valid,
   output logic              eng_cmd_rd,
   output logic [BYTE_W-1:0] eng_cmd_byte,
   input  logic              eng_cmd_pop,
   input  logic              eng_rx_push,
   input  logic [BYTE_W-1:0] eng_rx_byte,
   output logic [LVL_W-1:0]  tx_level,
   output logic [LVL_W-1:0]  rx_level,
   output logic              tx_empty_irq,
   output logic              rx_full_irq,
   output logic              tx_over,
   output logic              rx_over,
   output logic              rx_under
);
   generate
      if (RD_W < BYTE_W) begin : g_bad_rdw
         $error("i2cm_cmd_queue: RD_W must hold a full byte");
      end
   endgenerate

   cmd_t              tx_head;
   logic [CMD_W-1:0]  tx_dout;
   logic              tx_full, tx_empty;
   logic [BYTE_W-1:0] rx_dout;
   logic              rx_full, rx_empty;
   logic [EV_N-1:0]   ev_raw, ev_pulse;

   i2cm_q_fifo #(.WIDTH(CMD_W), .DEPTH(DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (abort),
      .push  (host_wr_en),
      .din   (host_wr_data),
      .pop   (eng_cmd_pop),
      .dout  (tx_dout),
      .level (tx_level),
      .full  (tx_full),
      .empty (tx_empty)
   );

   i2cm_q_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (abort),
      .push  (eng_rx_push),
      .din   (eng_rx_byte),
      .pop   (host_rd_en),
      .dout  (rx_dout),
      .level (rx_level),
      .full  (rx_full),
      .empty (rx_empty)
   );

   // engine view of the head command; a read request carries no byte
   assign tx_head       = cmd_t'(tx_dout);
   assign eng_cmd_valid = ~tx_empty;
   assign eng_cmd_rd    = ~tx_empty & tx_head.rd;
   assign eng_cmd_byte  = (tx_empty | tx_head.rd) ? '0 : tx_head.dat;

   assign host_rd_data  = rx_empty ? '0 : RD_W'(rx_dout);

   i2cm_q_thresh #(.LW(LVL_W), .ABOVE(1'b0)) u_tx_thr (
      .level  (tx_level),
      .thresh (tx_thresh),
      .hit    (tx_empty_irq)
   );

   i2cm_q_thresh #(.LW(LVL_W), .ABOVE(1'b1)) u_rx_thr (
      .level  (rx_level),
      .thresh (rx_thresh),
      .hit    (rx_full_irq)
   );

   // occupancy is judged before any same-cycle pop; abort silences events
   always_comb begin
      ev_raw              = '0;
      ev_raw[EV_TX_OVER]  = host_wr_en  & tx_full  & ~abort;
      ev_raw[EV_RX_OVER]  = eng_rx_push & rx_full  & ~abort;
      ev_raw[EV_RX_UNDER] = host_rd_en  & rx_empty & ~abort;
   end

   i2cm_q_evt #(.N(EV_N)) u_evt (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (ev_raw),
      .pulse (ev_pulse)
   );

   assign tx_over  = ev_pulse[EV_TX_OVER];
   assign rx_over  = ev_pulse[EV_RX_OVER];
   assign rx_under = ev_pulse[EV_RX_UNDER];
endmodule

// File: rtl/i2cm_q_chk.sv
module i2cm_q_chk #(
   parameter int DEPTH  = 8,
   parameter int RD_W   = 16,
   parameter int LVL_W  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_wr_en,
   input logic             host_rd_en,
   input logic [RD_W-1:0]  host_rd_data,
   input logic [LVL_W-1:0] tx_thresh,
   input logic [LVL_W-1:0] rx_thresh,
   input logic             abort,
   input logic             eng_cmd_valid,
   input logic             eng_cmd_rd,
   input logic [7:0]       eng_cmd_byte,
   input logic             eng_cmd_pop,
   input logic             eng_rx_push,
   input logic [LVL_W-1:0] tx_level,
   input logic [LVL_W-1:0] rx_level,
   input logic             tx_empty_irq,
   input logic             rx_full_irq,
   input logic             tx_over,
   input logic             rx_over,
   input logic             rx_under
);
   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

   p_level_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= FULL_LVL && rx_level <= FULL_LVL);

   p_tx_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr_en && !eng_cmd_pop && !abort && tx_level < FULL_LVL
      |=> tx_level == $past(tx_level) + LVL_W'(1));

   p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_valid == (tx_level != '0));

   p_rd_no_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_rd |-> eng_cmd_byte == '0);

   p_tx_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty_irq == (tx_level <= tx_thresh));

   p_rx_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full_irq == (rx_level > rx_thresh));

   p_rd_zext_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd_data >> 8) == '0);

   p_tx_over_r8: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr_en && !eng_cmd_pop && !abort && tx_level == FULL_LVL
      |=> tx_over && tx_level == FULL_LVL);

   p_rx_over_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rx_push && !host_rd_en && !abort && rx_level == FULL_LVL
      |=> rx_over && rx_level == FULL_LVL);

   p_rx_under_r10: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd_en && !abort && rx_level == '0 |=> rx_under);

   p_abort_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> tx_level == '0 && rx_level == '0);

   p_abort_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !tx_over && !rx_over && !rx_under);

   p_empty_pop_r12: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_pop && !host_wr_en && tx_level == '0 |=> tx_level == '0 && !tx_over);
endmodule

bind i2cm_cmd_queue i2cm_q_chk #(.DEPTH(DEPTH), .RD_W(RD_W), .LVL_W(LVL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .host_wr_en   (host_wr_en),
   .host_rd_en   (host_rd_en),
   .host_rd_data (host_rd_data),
   .tx_thresh    (tx_thresh),
   .rx_thresh    (rx_thresh),
   .abort        (abort),
   .eng_cmd_valid(eng_cmd_valid),
   .eng_cmd_rd   (eng_cmd_rd),
   .eng_cmd_byte (eng_cmd_byte),
   .eng_cmd_pop  (eng_cmd_pop),
   .eng_rx_push  (eng_rx_push),
   .tx_level     (tx_level),
   .rx_level     (rx_level),
   .tx_empty_irq (tx_empty_irq),
   .rx_full_irq  (rx_full_irq),
   .tx_over      (tx_over),
   .rx_over      (rx_over),
   .rx_under     (rx_under)
);

// File: tb/sim_i2cm_cmd_queue.sv
`timescale 1ns/100ps
module sim_i2cm_cmd_queue;
   localparam int DEPTH = 8;
   localparam int RD_W  = 16;
   localparam int LW    = 4;

   // write-then-drain vectors: command word per entry
   localparam logic [8:0] TBL [8] = '{
      9'h0A5, 9'h13C, 9'h000, 9'h0FF, 9'h1FF, 9'h05A, 9'h100, 9'h081
   };

   logic clk = 1'b0;
   logic rst_n;
   logic host_wr_en, host_rd_en, abort, eng_cmd_pop, eng_rx_push;
   logic [8:0] host_wr_data;
   logic [RD_W-1:0] host_rd_data;
   logic [LW-1:0] tx_thresh, rx_thresh, tx_level, rx_level;
   logic eng_cmd_valid, eng_cmd_rd, tx_empty_irq, rx_full_irq;
   logic tx_over, rx_over, rx_under;
   logic [7:0] eng_cmd_byte, eng_rx_byte;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   i2cm_cmd_queue #(.DEPTH(DEPTH), .RD_W(RD_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
      .host_rd_en(host_rd_en), .host_rd_data(host_rd_data),
      .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .abort(abort),
      .eng_cmd_valid(eng_cmd_valid), .eng_cmd_rd(eng_cmd_rd),
      .eng_cmd_byte(eng_cmd_byte), .eng_cmd_pop(eng_cmd_pop),
      .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte),
      .tx_level(tx_level), .rx_level(rx_level),
      .tx_empty_irq(tx_empty_irq), .rx_full_irq(rx_full_irq),
      .tx_over(tx_over), .rx_over(rx_over), .rx_under(rx_under)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [8:0] w);
      host_wr_en = 1'b1; host_wr_data = w;
      step();
      host_wr_en = 1'b0;
   endtask

   task automatic pop();
      eng_cmd_pop = 1'b1;
      step();
      eng_cmd_pop = 1'b0;
   endtask

   task automatic push(input logic [7:0] b);
      eng_rx_push = 1'b1; eng_rx_byte = b;
      step();
      eng_rx_push = 1'b0;
   endtask

   task automatic rd(output int d);
      host_rd_en = 1'b1;
      #1 d = int'(host_rd_data);
      step();
      host_rd_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      int d;
      rst_n = 1'b0; host_wr_en = 0; host_rd_en = 0; abort = 0;
      eng_cmd_pop = 0; eng_rx_push = 0; host_wr_data = '0; eng_rx_byte = '0;
      tx_thresh = 4'd7; rx_thresh = 4'd0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 tx_level", int'(tx_level), 0);
      chk("R1 rx_level", int'(rx_level), 0);
      chk("R1 valid", int'(eng_cmd_valid), 0);
      chk("R1 tx_empty_irq", int'(tx_empty_irq), 1);
      chk("R1 rx_full_irq", int'(rx_full_irq), 0);
      chk("R1 events", int'({tx_over, rx_over, rx_under}), 0);
      step();

      // table walk: fill the transmit queue (R4, R5)
      for (int i = 0; i < 8; i++) begin
         wr(TBL[i]);
         chk("R4 tx_level fill", int'(tx_level), i + 1);
         chk("R5 tx_empty_irq", int'(tx_empty_irq), (i + 1 <= 7) ? 1 : 0);
      end
      // R8 write to full queue
      wr(9'h033);
      chk("R8 tx_over", int'(tx_over), 1);
      chk("R8 level held", int'(tx_level), 8);
      step();
      chk("R8 pulse one cycle", int'(tx_over), 0);
      // drain in order (R2, R3)
      for (int i = 0; i < 8; i++) begin
         chk("R2 valid", int'(eng_cmd_valid), 1);
         chk("R2 R3 rd flag", int'(eng_cmd_rd), int'(TBL[i][8]));
         chk("R2 R3 byte", int'(eng_cmd_byte), TBL[i][8] ? 0 : int'(TBL[i][7:0]));
         pop();
      end
      chk("R4 tx drained", int'(tx_level), 0);
      chk("R2 valid after drain", int'(eng_cmd_valid), 0);

      // R12 pop on empty
      pop();
      chk("R12 tx_level", int'(tx_level), 0);
      chk("R12 no event", int'(tx_over), 0);

      // R5 lower threshold
      tx_thresh = 4'd2;
      wr(9'h011); wr(9'h022); wr(9'h033);
      chk("R5 above thresh", int'(tx_empty_irq), 0);
      pop();
      chk("R5 at thresh", int'(tx_empty_irq), 1);
      chk("R2 order after pop", int'(eng_cmd_byte), 'h22);
      pop(); pop();

      // R6 receive threshold
      push(8'h11);
      chk("R6 thresh0 one byte", int'(rx_full_irq), 1);
      chk("R4 rx_level", int'(rx_level), 1);
      rx_thresh = 4'd1;
      #1 chk("R6 thresh1 one byte", int'(rx_full_irq), 0);
      for (int i = 1; i < 8; i++) push(8'(8'h11 + i * 8'h23));
      chk("R6 full above", int'(rx_full_irq), 1);
      chk("R4 rx full", int'(rx_level), 8);
      push(8'hEE);
      chk("R9 rx_over", int'(rx_over), 1);
      chk("R9 level held", int'(rx_level), 8);
      for (int i = 0; i < 8; i++) begin
         rd(d);
         chk("R7 data", d, int'(8'(8'h11 + i * 8'h23)));
      end
      chk("R7 rx drained", int'(rx_level), 0);
      rd(d);
      chk("R10 empty data", d, 0);
      chk("R10 rx_under", int'(rx_under), 1);
      chk("R10 level", int'(rx_level), 0);

      // R11 abort with simultaneous traffic
      wr(9'h0C1); wr(9'h0C2); wr(9'h0C3);
      push(8'h77); push(8'h78);
      abort = 1'b1; host_wr_en = 1'b1; host_wr_data = 9'h0D0;
      eng_rx_push = 1'b1; eng_rx_byte = 8'h99;
      step();
      abort = 1'b0; host_wr_en = 1'b0; eng_rx_push = 1'b0;
      chk("R11 tx flushed", int'(tx_level), 0);
      chk("R11 rx flushed", int'(rx_level), 0);
      chk("R11 no events", int'({tx_over, rx_over, rx_under}), 0);
      wr(9'h042);
      chk("R11 after flush", int'(eng_cmd_byte), 'h42);
      chk("R11 after flush level", int'(tx_level), 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule